// File: doc/BRIEF.md
# Quadword Multiply-by-Ten Unit

This unit takes a 128-bit unsigned operand and multiplies it by ten in one clock cycle. The product comes from two shifted copies of the operand, one moved left by three bits and one moved left by one bit, added together. No general multiplier is used. Two independent control bits pick one of four variants. The first bit adds a decimal digit taken from a second operand. The second bit selects whether the unit returns the product or the part of the product that overflows above 128 bits.

The inputs are captured through a registered output stage whenever `go` is high. A valid pulse appears on the cycle after each capture and lines up with the new result. The unit holds its last result until the next capture.

Top module: `mul_ten_q`

## Requirements
- R1: The output holds the low 128 bits of A*10 when neither mode bit is set (`digit_mode`=0, `carry_mode`=0).
- R2: With `digit_mode`=1, the low 4 bits of `opnd_b` form a digit d, and the result is the low 128 bits of A*10+d.
- R3: A digit nibble of value 10 through 15 is replaced by zero, so the result is the same as adding nothing.
- R4: With `carry_mode`=1, bits [63:0] of the result hold the full product (including any digit added) shifted right by 128, and bits [127:64] are zero.
- R5: The carry-out value returned in carry mode never exceeds 9.
- R6: With `digit_mode`=0, `opnd_b` has no effect on the result.
- R7: `res` and `res_vld` update only on a rising clock edge. `res_vld` is high in exactly the cycle after a cycle with `go`=1. `res` keeps its value in cycles with `go`=0.
- R8: After reset, `res` is zero and `res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Capture the operands and mode bits this cycle |
| digit_mode | input | 1 | Add the decimal digit taken from `opnd_b[3:0]` |
| carry_mode | input | 1 | Return the overflow above bit 127 instead of the product |
| opnd_a | input | 128 | Multiplicand |
| opnd_b | input | 128 | Digit source; only bits [3:0] are used |
| res | output | 128 | Registered result |
| res_vld | output | 1 | High one cycle after a capture |

## Verification
The assertions check every cycle that the upper half of the result is zero and the carry value is at most nine after a carry-mode capture. They also check the valid flag's timing and that the result holds while `go` is low. The arithmetic itself cannot be checked that way. The bench compares the result against a 132-bit reference computed by its own functions. It covers the digit values 9, 10 and 15, operands of all ones and zero, and random operands. It also confirms that `opnd_b` is ignored outside digit mode.

// File: rtl/mul_ten_q.sv
module mul_ten_q #(
  parameter int W  = 128,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          digit_mode,
  input  logic          carry_mode,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  output logic [W-1:0]  res,
  output logic          res_vld
);
  localparam int HW = W / 2;
  localparam int XW = W + DW;

  logic [DW-1:0] nib, dig;
  logic [HW+3:0] lo_sum, hi_sum;
  logic [W-1:0]  prod_lo;
  logic [3:0]    ovf;
  logic [W-1:0]  nxt;

  assign nib = opnd_b[DW-1:0];
  assign dig = (digit_mode && nib < DW'(10)) ? nib : '0;

  // per-half shift-and-add, low carry rippled into high half
  assign lo_sum = ({4'b0, opnd_a[HW-1:0]} << 3) + ({4'b0, opnd_a[HW-1:0]} << 1)
                + {{(HW){1'b0}}, dig};
  assign hi_sum = ({4'b0, opnd_a[W-1:HW]} << 3) + ({4'b0, opnd_a[W-1:HW]} << 1)
                + {{(HW){1'b0}}, lo_sum[HW+3:HW]};
  assign prod_lo = {hi_sum[HW-1:0], lo_sum[HW-1:0]};
  assign ovf = hi_sum[HW+3:HW];

  assign nxt = carry_mode ? {{(W-4){1'b0}}, ovf} : prod_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= go;
      if (go) res <= nxt;
    end
  end
endmodule

// File: rtl/mul_ten_q_chk.sv
module mul_ten_q_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic         carry_mode,
  input logic [W-1:0] res,
  input logic         res_vld
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0; else seen <= 1'b1;

  assert_carry_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && carry_mode) |=> (res[W-1:64] == '0));

  assert_carry_max_nine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && carry_mode) |=> (res <= W'(9)));

  assert_vld_follows_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (res_vld == $past(go)));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(go)) |-> $stable(res));
endmodule

bind mul_ten_q mul_ten_q_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .carry_mode(carry_mode),
  .res(res), .res_vld(res_vld)
);

// File: tb/test_mul_ten_q.sv
module test_mul_ten_q;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, go = 0, dm = 0, cm = 0;
  logic [127:0] a = '0, b = '0, res;
  logic res_vld;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_ten_q i_mul_ten_q (.clk(clk), .rst_n(rst_n), .go(go), .digit_mode(dm),
    .carry_mode(cm), .opnd_a(a), .opnd_b(b), .res(res), .res_vld(res_vld));

  function automatic logic [131:0] ref_full(logic [127:0] x, logic [127:0] y, logic d);
    logic [3:0] n = y[3:0];
    logic [131:0] cin = (d && n <= 4'd9) ? 132'(n) : 132'd0;
    return 132'(x) * 132'd10 + cin;
  endfunction

  function automatic logic [127:0] ref_res(logic [127:0] x, logic [127:0] y, logic d, logic c);
    logic [131:0] f = ref_full(x, y, d);
    return c ? {124'd0, f[131:128]} : f[127:0];
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(string req, logic [127:0] x, logic [127:0] y, logic d, logic c);
    @(negedge clk); a = x; b = y; dm = d; cm = c; go = 1;
    @(negedge clk); go = 0;
    check(req, res, ref_res(x, y, d, c));
    check("R7 vld", {127'd0, res_vld}, 128'd1);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] held;
    logic [127:0] ones = '1;
    #(CLK_PERIOD*2); @(negedge clk);
    check("R8 res", res, '0);
    check("R8 vld", {127'd0, res_vld}, '0);
    rst_n = 1;
    run("R1 zero", '0, '0, 0, 0);
    run("R1 ones", ones, '0, 0, 0);
    run("R4 ones carry", ones, '0, 0, 1);
    check("R5 max", res, 128'd9);
    run("R2 nib9", ones, 128'h9, 1, 1);
    check("R5 ones+9", res, 128'd9);
    run("R2 nib9 prod", 128'd5, 128'h9, 1, 0);
    run("R3 nib10", 128'd5, 128'hA, 1, 0);
    run("R3 nib15", 128'd7, 128'hF, 1, 0);
    run("R3 nib15 carry", ones, 128'hF, 1, 1);
    run("R2 zero a", '0, 128'h3, 1, 0);
    run("R6 b ignored", 128'd12, 128'h5, 0, 0);
    check("R6 b ignored value", res, 128'd120);
    run("R1 half boundary", {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, '0, 0, 0);
    run("R2 half boundary", {64'd0, 64'h1999_9999_9999_9999}, 128'h6, 1, 0);
    held = res;
    @(negedge clk); a = '1; b = '1; dm = 1; cm = 1;
    @(negedge clk);
    check("R7 hold", res, held);
    check("R7 no vld", {127'd0, res_vld}, '0);
    void'($urandom(1234));
    for (int i = 0; i < 200; i++) begin
      logic [127:0] x = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] y = {$urandom, $urandom, $urandom, $urandom};
      logic d = 1'($urandom), c = 1'($urandom);
      run(d ? "R2 rand" : (c ? "R4 rand" : "R1 rand"), x, y, d, c);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule